// File: doc/BRIEF.md
# Receive Metaframe Status and CRC Checker

This block sits on the receive side of a lane and watches a word stream that has already been cut into metaframes. Each metaframe opens with a sync word and closes with a diagnostic word, and the word-type flags arrive with each word. Frame lock comes from an upstream synchronizer and is an input here. The block turns the sync word into a stretched start-of-metaframe pulse and stretches the lock level into a lock indication. It also recomputes a CRC32 over every complete metaframe and reports a mismatch as a stretched error pulse. A two-bit lane/link status is taken from each valid closing diagnostic word.

The CRC is an MSB-first, non-reflected CRC32 with a parameterised polynomial. It is seeded with all ones at the sync word and runs over every word up to and including the diagnostic word. The 32-bit check field of the diagnostic word counts as zero in that run. The field must equal the bitwise inverse of the final remainder.

Top module: `rxmf_status_crc`

## Requirements
- R1: A sync word (wordValid=1, wordSync=1) sampled while frameLock=1 raises rxFrameStart in the next cycle and holds it for exactly 3 cycles.
- R2: rxLockOut is high in the cycle after frameLock is sampled high and stays high for exactly 3 cycles after the last cycle frameLock was sampled high.
- R3: The CRC is seeded with 32'hFFFFFFFF at the sync word, shifts in each 64-bit word from bit 63 down to bit 0 using polynomial 32'h1EDC6F41, and covers the sync word, the payload words and the diagnostic word with bits [31:0] forced to zero. The expected check value is the bitwise inverse of the result.
- R4: When a diagnostic word (wordDiag=1) closes a locked metaframe and bits [31:0] differ from the expected check value, rxCrcErr rises in the next cycle and stays high for exactly 3 cycles.
- R5: A diagnostic word whose bits [31:0] equal the expected check value raises no rxCrcErr.
- R6: A diagnostic word that closes a locked metaframe and whose type field bits [63:58] equal 6'h19 loads bits [33:32] into rxStatus in the next cycle. rxStatus[1]=1 means lane operational and rxStatus[0]=1 means link operational.
- R7: A closing diagnostic word whose type field is not 6'h19 leaves rxStatus unchanged. Its CRC is still checked.
- R8: If frameLock is sampled low inside a metaframe, that partial metaframe is discarded. Its diagnostic word raises no rxCrcErr and does not change rxStatus. Checking resumes at the next sync word taken under lock.
- R9: During and just after reset, rxFrameStart, rxLockOut and rxCrcErr are 0 and rxStatus is 2'b00.
- R10: A diagnostic word seen before any sync word has opened a metaframe is ignored: no rxCrcErr and no status change.
- R11: Cycles with wordValid=0 neither advance the CRC nor close or open a metaframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Word on wordData is valid this cycle |
| wordData | input | 64 | Received word |
| wordSync | input | 1 | Word is a sync word (opens a metaframe) |
| wordDiag | input | 1 | Word is a diagnostic word (closes a metaframe) |
| frameLock | input | 1 | Metaframe delineation held by the upstream synchronizer |
| rxFrameStart | output | 1 | Stretched start-of-metaframe indication |
| rxLockOut | output | 1 | Stretched lock indication |
| rxStatus | output | 2 | Latched status: bit 1 lane operational, bit 0 link operational |
| rxCrcErr | output | 1 | Stretched CRC mismatch indication at metaframe end |

## Verification
The assertions assume that wordSync and wordDiag are never both set on one valid word. They also assume that a diagnostic word only counts once an open metaframe has been seen under lock. The stimulus always flags at most one word type per word. It builds metaframes with a bench-computed check field, and it changes frameLock only on word boundaries. Gaps with wordValid low are inserted inside metaframes, and lock drops are placed between a sync word and its diagnostic word. This exercises the discard path without violating those assumptions.

// File: rtl/rxmf_pkg.sv
package rxmf_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic syncAcc;    // sync word accepted under lock: seed CRC
    logic wordStep;   // payload word inside an open metaframe
    logic diagCheck;  // diagnostic word closing an open metaframe
  } mfStrobe_t;

  localparam int unsigned CRC_W = 32;

endpackage

// File: rtl/rxmf_stretch.sv
module rxmf_stretch #(
  parameter int unsigned LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pulseIn,
  output logic pulseOut
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)               cntQ <= '0;
    else if (pulseIn)        cntQ <= CW'(LEN);
    else if (cntQ != '0)     cntQ <= cntQ - 1'b1;
  end

  assign pulseOut = (cntQ != '0);

  // Covers the rising edge of R1, R2 and R4 for every instance.
  p_stretch_on_r1: assert property (@(posedge clk) disable iff (!rstN)
    pulseIn |=> pulseOut);

  // Three quiet input cycles in a row leave the output low (R4 length bound).
  p_stretch_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseIn && $past(!pulseIn) && $past(!pulseIn, 2)) |=> !pulseOut);

endmodule

// File: rtl/rxmf_ctrl.sv
module rxmf_ctrl
  import rxmf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       wordSync,
  input  logic       wordDiag,
  input  logic       frameLock,
  output mfStrobe_t  strobe
);
  logic inFrameQ;

  always_comb begin
    strobe.syncAcc   = wordValid && wordSync && frameLock;
    strobe.wordStep  = wordValid && inFrameQ && frameLock && !wordSync && !wordDiag;
    strobe.diagCheck = wordValid && inFrameQ && frameLock && !wordSync && wordDiag;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 inFrameQ <= 1'b0;
    else if (!frameLock)       inFrameQ <= 1'b0;
    else if (strobe.syncAcc)   inFrameQ <= 1'b1;
    else if (strobe.diagCheck) inFrameQ <= 1'b0;
  end

  // A lost lock discards the open frame: the next word cannot close it.
  p_lockdrop_discard_r8: assert property (@(posedge clk) disable iff (!rstN)
    !frameLock |=> !strobe.diagCheck);

  // A closed frame needs a fresh sync before another check (R10).
  p_close_needs_sync_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.diagCheck |=> !strobe.diagCheck);

  // Strobes are mutually exclusive.
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.syncAcc, strobe.wordStep, strobe.diagCheck}));

endmodule

// File: rtl/rxmf_datapath.sv
module rxmf_datapath
  import rxmf_pkg::*;
#(
  parameter int unsigned         WORD_W    = 64,
  parameter int unsigned         TYPE_W    = 6,
  parameter logic [TYPE_W-1:0]   DIAG_TYPE = 6'h19,
  parameter logic [CRC_W-1:0]    POLY      = 32'h1EDC6F41
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfStrobe_t         strobe,
  input  logic [WORD_W-1:0] wordData,
  output logic [1:0]        statusQ,
  output logic              errEvent
);
  localparam int unsigned  STAT_LSB = CRC_W;
  localparam logic [CRC_W-1:0] SEED = '1;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction

  logic [CRC_W-1:0]  crcQ;
  logic [CRC_W-1:0]  crcSeedIn;
  logic [CRC_W-1:0]  crcNext;
  logic [CRC_W-1:0]  crcFinal;
  logic [WORD_W-1:0] diagMasked;
  logic              typeOk;
  logic              crcBad;

  assign crcSeedIn  = strobe.syncAcc ? SEED : crcQ;
  assign crcNext    = crcStep(crcSeedIn, wordData);
  assign diagMasked = {wordData[WORD_W-1:CRC_W], {CRC_W{1'b0}}};
  assign crcFinal   = crcStep(crcQ, diagMasked);
  assign crcBad     = (~crcFinal) != wordData[CRC_W-1:0];
  assign typeOk     = wordData[WORD_W-1 -: TYPE_W] == DIAG_TYPE;
  assign errEvent   = strobe.diagCheck && crcBad;

  always_ff @(posedge clk) begin
    if (!rstN)                                 crcQ <= SEED;
    else if (strobe.syncAcc || strobe.wordStep) crcQ <= crcNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            statusQ <= 2'b00;
    else if (strobe.diagCheck && typeOk)  statusQ <= wordData[STAT_LSB+1:STAT_LSB];
  end

  p_status_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.diagCheck && typeOk) |=> statusQ == $past(wordData[STAT_LSB+1:STAT_LSB]));

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.diagCheck && typeOk) |=> $stable(statusQ));

  p_crc_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.syncAcc || strobe.wordStep) |=> $stable(crcQ));

endmodule

// File: rtl/rxmf_status_crc.sv
module rxmf_status_crc
  import rxmf_pkg::*;
#(
  parameter int unsigned       WORD_W    = 64,
  parameter int unsigned       TYPE_W    = 6,
  parameter logic [TYPE_W-1:0] DIAG_TYPE = 6'h19,
  parameter logic [31:0]       POLY      = 32'h1EDC6F41,
  parameter int unsigned       STRETCH   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordSync,
  input  logic              wordDiag,
  input  logic              frameLock,
  output logic              rxFrameStart,
  output logic              rxLockOut,
  output logic [1:0]        rxStatus,
  output logic              rxCrcErr
);
  localparam int unsigned N_STR = 3;

  mfStrobe_t        strobe;
  logic             errEvent;
  logic [N_STR-1:0] pulseIn;
  logic [N_STR-1:0] pulseOut;

  rxmf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordSync(wordSync),
    .wordDiag(wordDiag), .frameLock(frameLock), .strobe(strobe)
  );

  rxmf_datapath #(
    .WORD_W(WORD_W), .TYPE_W(TYPE_W), .DIAG_TYPE(DIAG_TYPE), .POLY(POLY)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordData(wordData),
    .statusQ(rxStatus), .errEvent(errEvent)
  );

  assign pulseIn = {errEvent, frameLock, strobe.syncAcc};

  for (genvar g = 0; g < N_STR; g++) begin : g_str
    rxmf_stretch #(.LEN(STRETCH)) str_i (
      .clk(clk), .rstN(rstN), .pulseIn(pulseIn[g]), .pulseOut(pulseOut[g])
    );
  end

  assign rxFrameStart = pulseOut[0];
  assign rxLockOut    = pulseOut[1];
  assign rxCrcErr     = pulseOut[2];

endmodule

// File: tb/rxmf_status_crc_tb_top.sv
`timescale 1ns/1ps
module rxmf_status_crc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [63:0] wordData = '0;
  logic        wordSync = 1'b0;
  logic        wordDiag = 1'b0;
  logic        frameLock = 1'b0;
  logic        rxFrameStart, rxLockOut, rxCrcErr;
  logic [1:0]  rxStatus;

  always #2.5 clk = ~clk;

  rxmf_status_crc dut_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .wordSync(wordSync), .wordDiag(wordDiag), .frameLock(frameLock),
    .rxFrameStart(rxFrameStart), .rxLockOut(rxLockOut),
    .rxStatus(rxStatus), .rxCrcErr(rxCrcErr)
  );

  int total = 0;
  int bad = 0;
  bit started = 0;
  int errCycles = 0;
  int fsCycles = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] refCrc(input bit [31:0] c, input bit [63:0] d);
    bit [31:0] r = c;
    for (int i = 63; i >= 0; i--) begin
      bit fb = r[31] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 32'h1EDC6F41;
    end
    return r;
  endfunction

  // Behavioural reference model, advanced on each rising edge.
  bit        mIn = 0;
  bit [31:0] mCrc = '1;
  bit [1:0]  mStat = 0;
  int        mFs = 0, mLk = 0, mEr = 0;

  always @(posedge clk) begin
    bit sAcc, dChk, stp, badC;
    bit [31:0] fin;
    started = 1;
    if (!rstN) begin
      mIn = 0; mCrc = '1; mStat = 0; mFs = 0; mLk = 0; mEr = 0;
    end else begin
      sAcc = wordValid && wordSync && frameLock;
      dChk = wordValid && wordDiag && !wordSync && mIn && frameLock;
      stp  = wordValid && !wordSync && !wordDiag && mIn && frameLock;
      badC = 0;
      if (dChk) begin
        fin  = refCrc(mCrc, {wordData[63:32], 32'h0});
        badC = (~fin) != wordData[31:0];
        if (wordData[63:58] == 6'h19) mStat = wordData[33:32];
      end
      if (sAcc)      mCrc = refCrc(32'hFFFFFFFF, wordData);
      else if (stp)  mCrc = refCrc(mCrc, wordData);
      if (!frameLock) mIn = 0;
      else if (sAcc)  mIn = 1;
      else if (dChk)  mIn = 0;
      mFs = sAcc      ? 3 : (mFs > 0 ? mFs - 1 : 0);
      mLk = frameLock ? 3 : (mLk > 0 ? mLk - 1 : 0);
      mEr = (dChk && badC) ? 3 : (mEr > 0 ? mEr - 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R1 frame start vs model", 32'(rxFrameStart), 32'(mFs != 0));
      chk("R2 lock vs model", 32'(rxLockOut), 32'(mLk != 0));
      chk("R4 crc err vs model", 32'(rxCrcErr), 32'(mEr != 0));
      chk("R6 status vs model", 32'(rxStatus), 32'(mStat));
      if (rxCrcErr) errCycles++;
      if (rxFrameStart) fsCycles++;
    end
  end

  task automatic putWord(input logic [63:0] d, input logic s, input logic g, input logic v);
    @(posedge clk); #1;
    wordData = d; wordSync = s; wordDiag = g; wordValid = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) putWord(64'h0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // One metaframe; optional gap inside, optional corrupt check field or type.
  task automatic sendFrame(input int nPay, input logic [1:0] st, input bit corrupt,
                           input bit badType, input bit gap);
    bit [31:0]   c;
    logic [63:0] d;
    logic [5:0]  tf;
    d = rnd64();
    c = refCrc(32'hFFFFFFFF, d);
    putWord(d, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < nPay; i++) begin
      if (gap && i == 1) idle(2);
      d = rnd64();
      c = refCrc(c, d);
      putWord(d, 1'b0, 1'b0, 1'b1);
    end
    tf = badType ? 6'h2A : 6'h19;
    d = {tf, 24'($urandom), st, 32'h0};
    c = refCrc(c, d);
    d[31:0] = (~c) ^ (corrupt ? 32'h0000_0100 : 32'h0);
    putWord(d, 1'b0, 1'b1, 1'b1);
    idle(5);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 frame start in reset", 32'(rxFrameStart), 0);
    chk("R9 lock in reset", 32'(rxLockOut), 0);
    chk("R9 crc err in reset", 32'(rxCrcErr), 0);
    chk("R9 status in reset", 32'(rxStatus), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk("R9 status after reset", 32'(rxStatus), 0);

    putWord(64'h0, 1'b0, 1'b0, 1'b0);
    frameLock = 1'b1;
    idle(3);

    // R10: stray diagnostic word before any sync
    errCycles = 0;
    putWord({6'h19, 24'h0, 2'b01, 32'hDEAD_BEEF}, 1'b0, 1'b1, 1'b1);
    idle(5);
    chk("R10 no err on stray diag", 32'(errCycles), 0);
    chk("R10 status unchanged", 32'(rxStatus), 0);

    // R3, R5, R6, R1: good frame
    errCycles = 0; fsCycles = 0;
    sendFrame(4, 2'b11, 0, 0, 0);
    chk("R5 no err on good frame", 32'(errCycles), 0);
    chk("R6 status loaded 11", 32'(rxStatus), 2'b11);
    chk("R1 frame start width", 32'(fsCycles), 3);

    // R4: corrupted check field
    errCycles = 0;
    sendFrame(3, 2'b10, 1, 0, 0);
    chk("R4 err width", 32'(errCycles), 3);
    chk("R6 status loaded 10", 32'(rxStatus), 2'b10);

    // R7: wrong type field, good CRC
    errCycles = 0;
    sendFrame(5, 2'b01, 0, 1, 0);
    chk("R7 status held", 32'(rxStatus), 2'b10);
    chk("R7 crc still clean", 32'(errCycles), 0);

    // R11: gaps inside a frame
    errCycles = 0;
    sendFrame(4, 2'b00, 0, 0, 1);
    chk("R11 gap frame no err", 32'(errCycles), 0);
    chk("R11 gap frame status", 32'(rxStatus), 2'b00);

    // R8: lock drop mid-frame, then bad diag
    errCycles = 0;
    putWord(rnd64(), 1'b1, 1'b0, 1'b1);
    putWord(rnd64(), 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1 frameLock = 1'b0; wordValid = 1'b0;
    @(posedge clk); #1 frameLock = 1'b1;
    putWord({6'h19, 24'h0, 2'b11, 32'h1234_5678}, 1'b0, 1'b1, 1'b1);
    idle(5);
    chk("R8 no err after lock drop", 32'(errCycles), 0);
    chk("R8 status untouched", 32'(rxStatus), 2'b00);

    // R8: checking resumes on next sync
    errCycles = 0;
    sendFrame(2, 2'b01, 1, 0, 0);
    chk("R8 resumed err", 32'(errCycles), 3);
    chk("R8 resumed status", 32'(rxStatus), 2'b01);

    // R2: lock stretch after drop
    @(posedge clk); #1 frameLock = 1'b0;
    @(negedge clk); chk("R2 lock hold 1", 32'(rxLockOut), 1);
    @(negedge clk); chk("R2 lock hold 2", 32'(rxLockOut), 1);
    @(negedge clk); chk("R2 lock hold 3", 32'(rxLockOut), 1);
    @(negedge clk); chk("R2 lock released", 32'(rxLockOut), 0);
    // R1: sync without lock is not a start
    fsCycles = 0;
    putWord(rnd64(), 1'b1, 1'b0, 1'b1);
    idle(5);
    chk("R1 no start without lock", 32'(fsCycles), 0);

    finishRun();
  end

endmodule